// File: doc/BRIEF.md
# Audio Sample FIFO with Threshold Status

This block buffers audio samples for one direction of a serial audio port. It holds eight 32-bit words in first-in, first-out order. A producer pushes words in and a consumer pops them out. The block reports how many words it holds, whether it is full or empty, and a threshold status. The direction is chosen at build time through a parameter. A playback (transmit) instance raises its threshold status when the buffer is running low. A capture (receive) instance raises it when enough words have arrived.

Errors are reported through two flags that stay set until they are cleared. Pushing into a full buffer sets the overflow flag. Popping an empty buffer sets the underflow flag. Software clears a flag by driving its clear input for one cycle.

A clear strobe starts a one-cycle flush. The flush resets the read and write positions without erasing the stored words. A DMA request follows the fill state, so a DMA engine can keep a playback buffer topped up or drain a capture buffer.

Top module: `audio_fifo_thresh`

## Requirements
- R1: After reset the outputs are as follows: `level` is 0, `empty` is 1, `full` is 0, `overflow` is 0, `underflow` is 0 and `clear_busy` is 0.
- R2: Words come out in the order they were pushed. `pop_data` always shows the oldest stored word, without waiting for a clock edge. `level` counts from 0 to 8, `full` is 1 exactly at level 8, and `empty` is 1 exactly at level 0. An accepted push or pop changes `level` at the next rising edge.
- R3: A push and a pop in the same cycle on a non-empty buffer leave `level` unchanged. The pushed word is stored even when the buffer was full in that cycle.
- R4: A push while the buffer is full, with no pop in the same cycle, discards the word and leaves `level` unchanged. `overflow` is 1 from the next edge and stays 1 until it is cleared.
- R5: A pop while the buffer is empty removes nothing. `underflow` is 1 from the next edge and stays 1 until it is cleared. A push in that same cycle is still stored.
- R6: Driving `ovf_clr` or `udf_clr` high for one cycle clears the matching flag at the next edge. If a new error event of that kind occurs in the same cycle as the clear, the flag stays 1.
- R7: With `IS_RX`=0 (transmit), `thresh_flag` is 1 exactly when `level` is less than or equal to the 3-bit `threshold`.
- R8: With `IS_RX`=1 (receive), `thresh_flag` is 1 exactly when `level` is greater than or equal to `threshold`.
- R9: A `clear_req` sampled at an edge makes `clear_busy` 1 for the following cycle. During that cycle, pushes and pops are ignored and raise no flag. At the edge that ends the cycle, `level` becomes 0 and `clear_busy` falls, unless `clear_req` is still high. Stored words are not altered: the word held in the first slot appears on `pop_data` after the clear.
- R10: With `dma_en` high, `dma_req` is 1 when the buffer is not full on a transmit instance, and when it is not empty on a receive instance. With `dma_en` low, `dma_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_valid | input | 1 | Push `push_data` this cycle |
| push_data | input | DATA_W | Word to store |
| pop_req | input | 1 | Remove the oldest word this cycle |
| pop_data | output | DATA_W | Oldest stored word |
| clear_req | input | 1 | Start a flush of the read and write positions |
| clear_busy | output | 1 | Flush in progress; clears itself |
| threshold | input | TH_W | Threshold level |
| dma_en | input | 1 | Allow DMA requests |
| ovf_clr | input | 1 | Clear the overflow flag (write-one) |
| udf_clr | input | 1 | Clear the underflow flag (write-one) |
| level | output | LW | Number of stored words |
| full | output | 1 | Buffer holds DEPTH words |
| empty | output | 1 | Buffer holds no word |
| thresh_flag | output | 1 | Threshold status for the chosen direction |
| overflow | output | 1 | Sticky push-while-full flag |
| underflow | output | 1 | Sticky pop-while-empty flag |
| dma_req | output | 1 | DMA transfer request |

## Verification
The bench targets the following corner cases, each with the failure it would expose:

- Simultaneous push and pop on a full buffer: a design that gates the push on `full` alone would drop that word and lower the level.
- Simultaneous pop and push on an empty buffer: a design that gets this wrong would either lose the push or wrap the level below zero.
- A flag clear that coincides with a new error: a design that gives the clear priority would lose the error event.
- A flush that coincides with traffic: a design that lets that traffic through would leave a nonzero level or raise false flags.
- A wrapped write position after a flush: a design that erases slots or resets only one pointer would show the wrong word on `pop_data`.
- Every threshold value at levels 0 and 8, on both directions at once: an off-by-one or reversed comparison would show at these extremes.

// File: rtl/audio_fifo_thresh.sv
module audio_fifo_thresh #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int TH_W   = 3,
  parameter bit IS_RX  = 1'b0,
  localparam int AW    = $clog2(DEPTH),
  localparam int LW    = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  output logic [DATA_W-1:0] pop_data,
  input  logic              clear_req,
  output logic              clear_busy,
  input  logic [TH_W-1:0]   threshold,
  input  logic              dma_en,
  input  logic              ovf_clr,
  input  logic              udf_clr,
  output logic [LW-1:0]     level,
  output logic              full,
  output logic              empty,
  output logic              thresh_flag,
  output logic              overflow,
  output logic              underflow,
  output logic              dma_req
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [LW-1:0]     count;
  logic              clr_q, ovf_q, udf_q;
  logic              pop_ok, push_ok, ovf_evt, udf_evt;
  logic [LW-1:0]     th_ext;

  assign full    = (count == LW'(DEPTH));
  assign empty   = (count == '0);
  assign pop_ok  = pop_req & ~empty & ~clr_q;
  assign push_ok = push_valid & ~clr_q & (~full | pop_ok);
  assign ovf_evt = push_valid & ~clr_q & ~push_ok;
  assign udf_evt = pop_req & ~clr_q & empty;
  assign th_ext  = LW'(threshold);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      clr_q  <= 1'b0;
      ovf_q  <= 1'b0;
      udf_q  <= 1'b0;
    end else begin
      clr_q <= clear_req;
      ovf_q <= ovf_evt | (ovf_q & ~ovf_clr);
      udf_q <= udf_evt | (udf_q & ~udf_clr);
      if (clr_q) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
        count  <= '0;
      end else begin
        if (push_ok) wr_ptr <= wr_ptr + AW'(1);
        if (pop_ok)  rd_ptr <= rd_ptr + AW'(1);
        case ({push_ok, pop_ok})
          2'b10:   count <= count + LW'(1);
          2'b01:   count <= count - LW'(1);
          default: count <= count;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  generate
    if (IS_RX) begin : g_rx
      assign thresh_flag = (count >= th_ext);
      assign dma_req     = dma_en & ~empty;
    end else begin : g_tx
      assign thresh_flag = (count <= th_ext);
      assign dma_req     = dma_en & ~full;
    end
  endgenerate

  assign pop_data   = mem[rd_ptr];
  assign level      = count;
  assign clear_busy = clr_q;
  assign overflow   = ovf_q;
  assign underflow  = udf_q;

endmodule

module audio_fifo_thresh_chk #(
  parameter int DEPTH = 8,
  parameter int LW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_valid,
  input logic          pop_req,
  input logic          clear_req,
  input logic          clear_busy,
  input logic          dma_en,
  input logic          ovf_clr,
  input logic          udf_clr,
  input logic [LW-1:0] level,
  input logic          full,
  input logic          empty,
  input logic          overflow,
  input logic          underflow,
  input logic          dma_req
);

  assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  assert_level_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && pop_req && !empty && !clear_busy |=> $stable(level));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && full && !pop_req && !clear_busy |=> overflow && full);

  assert_underflow_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop_req && empty && !clear_busy |=> underflow);

  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !ovf_clr |=> overflow);

  assert_udf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    underflow && !udf_clr |=> underflow);

  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear_busy |=> level == '0);

  assert_clear_selfclr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear_busy && !clear_req |=> !clear_busy);

  assert_dma_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> dma_en);

endmodule

bind audio_fifo_thresh audio_fifo_thresh_chk #(.DEPTH(DEPTH), .LW(LW)) chk_i (
  .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .pop_req(pop_req),
  .clear_req(clear_req), .clear_busy(clear_busy), .dma_en(dma_en),
  .ovf_clr(ovf_clr), .udf_clr(udf_clr), .level(level), .full(full),
  .empty(empty), .overflow(overflow), .underflow(underflow), .dma_req(dma_req)
);

// File: tb/audio_fifo_thresh_tb_top.sv
`timescale 1ns/1ps
module audio_fifo_thresh_tb_top;
  localparam int DW = 32;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push_valid = 0, pop_req = 0, clear_req = 0, dma_en = 0, ovf_clr = 0, udf_clr = 0;
  logic [DW-1:0] push_data = '0;
  logic [2:0] threshold = 3'd0;

  logic [DW-1:0] tx_pd, rx_pd;
  logic [3:0] tx_lvl, rx_lvl;
  logic tx_full, tx_empty, tx_th, tx_ovf, tx_udf, tx_dma, tx_cb;
  logic rx_full, rx_empty, rx_th, rx_ovf, rx_udf, rx_dma, rx_cb;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  audio_fifo_thresh #(.IS_RX(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
    .pop_req(pop_req), .pop_data(tx_pd), .clear_req(clear_req), .clear_busy(tx_cb),
    .threshold(threshold), .dma_en(dma_en), .ovf_clr(ovf_clr), .udf_clr(udf_clr),
    .level(tx_lvl), .full(tx_full), .empty(tx_empty), .thresh_flag(tx_th),
    .overflow(tx_ovf), .underflow(tx_udf), .dma_req(tx_dma));

  audio_fifo_thresh #(.IS_RX(1'b1)) dut_rx_i (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
    .pop_req(pop_req), .pop_data(rx_pd), .clear_req(clear_req), .clear_busy(rx_cb),
    .threshold(threshold), .dma_en(dma_en), .ovf_clr(ovf_clr), .udf_clr(udf_clr),
    .level(rx_lvl), .full(rx_full), .empty(rx_empty), .thresh_flag(rx_th),
    .overflow(rx_ovf), .underflow(rx_udf), .dma_req(rx_dma));

  logic [DW-1:0] m_q[$];
  logic [DW-1:0] m_mem [DEPTH];
  bit m_vld [DEPTH];
  int m_wp = 0, m_rp = 0;
  bit m_ovf = 0, m_udf = 0, m_clr = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    int n = m_q.size();
    bit e_tx_th = (n <= int'(threshold));
    bit e_rx_th = (n >= int'(threshold));
    bit e_tx_dma = dma_en && (n != DEPTH);
    bit e_rx_dma = dma_en && (n != 0);
    chk(tx_lvl == n && rx_lvl == n, "R2 level", {tx_lvl, rx_lvl}, n);
    chk(tx_full == (n == DEPTH) && rx_full == (n == DEPTH), "R2 full", tx_full, n == DEPTH);
    chk(tx_empty == (n == 0) && rx_empty == (n == 0), "R2 empty", tx_empty, n == 0);
    chk(tx_th == e_tx_th, "R7 tx threshold", tx_th, e_tx_th);
    chk(rx_th == e_rx_th, "R8 rx threshold", rx_th, e_rx_th);
    chk(tx_ovf == m_ovf && rx_ovf == m_ovf, "R4 overflow", tx_ovf, m_ovf);
    chk(tx_udf == m_udf && rx_udf == m_udf, "R5 underflow", tx_udf, m_udf);
    chk(tx_cb == m_clr && rx_cb == m_clr, "R9 clear_busy", tx_cb, m_clr);
    chk(tx_dma == e_tx_dma, "R10 tx dma", tx_dma, e_tx_dma);
    chk(rx_dma == e_rx_dma, "R10 rx dma", rx_dma, e_rx_dma);
    if (m_vld[m_rp])
      chk(tx_pd == m_mem[m_rp] && rx_pd == m_mem[m_rp], "R2 pop_data", tx_pd, m_mem[m_rp]);
  endtask

  task automatic step(input bit p, input logic [DW-1:0] d, input bit po,
                      input bit cl, input bit oc, input bit uc);
    bit is_full, is_empty, pop_ok, push_ok, oe, ue;
    push_valid = p; push_data = d; pop_req = po; clear_req = cl; ovf_clr = oc; udf_clr = uc;
    @(posedge clk);
    is_full = (m_q.size() == DEPTH);
    is_empty = (m_q.size() == 0);
    pop_ok = po && !is_empty && !m_clr;
    push_ok = p && !m_clr && (!is_full || pop_ok);
    oe = p && !m_clr && !push_ok;
    ue = po && !m_clr && is_empty;
    if (m_clr) begin
      m_q.delete(); m_wp = 0; m_rp = 0;
    end else begin
      if (pop_ok) begin void'(m_q.pop_front()); m_rp = (m_rp + 1) % DEPTH; end
      if (push_ok) begin
        m_q.push_back(d); m_mem[m_wp] = d; m_vld[m_wp] = 1; m_wp = (m_wp + 1) % DEPTH;
      end
    end
    m_ovf = oe || (m_ovf && !oc);
    m_udf = ue || (m_udf && !uc);
    m_clr = cl;
    @(negedge clk);
    compare();
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) m_vld[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(tx_lvl == 0 && tx_empty && !tx_full && !tx_ovf && !tx_udf && !tx_cb, "R1 reset tx", tx_lvl, 0);
    chk(rx_lvl == 0 && rx_empty && !rx_full && !rx_ovf && !rx_udf && !rx_cb, "R1 reset rx", rx_lvl, 0);
    compare();
    dma_en = 1; threshold = 3'd3;
    // R2 fill to full, R7/R8 thresholds swept by level
    for (int i = 0; i < DEPTH; i++) step(1, 32'hA000_0000 + i, 0, 0, 0, 0);
    // R4 overflow on push while full
    step(1, 32'hDEAD_0001, 0, 0, 0, 0);
    // R3 push+pop while full
    step(1, 32'hB000_0001, 1, 0, 0, 0);
    // R6 clear coinciding with new overflow keeps flag
    step(1, 32'hDEAD_0002, 0, 0, 1, 0);
    step(0, 0, 0, 0, 1, 0);
    // R7/R8 every threshold at level 8
    for (int t = 0; t < 8; t++) begin threshold = 3'(t); step(0, 0, 0, 0, 0, 0); end
    // drain
    for (int i = 0; i < DEPTH; i++) step(0, 0, 1, 0, 0, 0);
    for (int t = 0; t < 8; t++) begin threshold = 3'(t); step(0, 0, 0, 0, 0, 0); end
    // R5 underflow, then pop-empty with push
    step(0, 0, 1, 0, 0, 0);
    step(1, 32'hC000_0001, 1, 0, 0, 1);
    step(0, 0, 0, 0, 0, 1);
    step(0, 0, 1, 0, 0, 0);
    step(0, 0, 1, 0, 0, 1);
    // R10 dma off
    dma_en = 0;
    step(1, 32'hC000_0002, 0, 0, 0, 0);
    dma_en = 1;
    // R9 clear with traffic during busy cycle
    for (int i = 0; i < 5; i++) step(1, 32'hE000_0000 + i, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0);
    step(1, 32'hFFFF_0000, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    // R9 held strobe
    step(1, 32'h1111_0000, 0, 1, 0, 0);
    step(0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      threshold = 3'($urandom_range(0, 7));
      dma_en = ($urandom_range(0, 7) != 0);
      step($urandom_range(0, 1) == 1, $urandom, $urandom_range(0, 2) == 0,
           $urandom_range(0, 60) == 0, $urandom_range(0, 9) == 0, $urandom_range(0, 9) == 0);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule